// File: doc/BRIEF.md
# Packed Multi-Lane Signed MAC Unit

This block runs several narrow multiply-accumulates through one wide multiplier at the same time. On each accepted beat it takes `NLANE` activations of `AW` bits each and one shared signed weight of `WW` bits. The activations go into a single 27-bit operand. Each activation sits in its own lane field, `LANE_W` bits apart. A pre-adder stage forms that operand as a magnitude word minus a sign word, so two's-complement activations need no fabric adder. The 27×18 product is added into a 48-bit accumulator. When the run ends, each lane field is read back as that lane's dot product over all beats of the run.

Lanes whose sums go negative borrow from the lane above them. A small per-lane tracker keeps the exact value of each lane's sum modulo 4. It does this by adding up the two lowest bits of each lane's partial product. For every lane above lane 0, the tracker value is compared with the low two bits of that lane's accumulator field. When they differ, a borrow happened and the extracted value is raised by one. Lane width is derived as `AW + WW + log2(DEPTH)`. Elaboration stops if the packed operand would exceed 26 magnitude bits or the lanes would exceed 48 bits.

A run begins with a beat that has `in_start` set and ends with a beat that has `in_last` set. The lane results come out together with a one-cycle `out_valid` pulse.

Top module: `sdv_mac_top`

## Requirements
- R1: While `rst` is high and after it falls, before any run completes, `out_valid` is 0 and `out_lanes` is all zeros.
- R2: With `in_signed`=1, lane i takes its activation from `in_act[i*AW +: AW]` as a two's-complement value. Its result at `out_lanes[i*LANE_W +: LANE_W]` (two's complement, LANE_W = 11 by default) equals the sum over the run of activation times `in_wgt` (two's complement).
- R3: With `in_signed`=0, each activation is read as an unsigned value 0..2^AW−1, and the lane results follow the same sum rule as in R2.
- R4: The signed/unsigned choice applies per beat, so a run may mix both kinds of beat.
- R5: A valid beat with `in_start`=1 discards every earlier partial sum, even from a run that never saw `in_last`.
- R6: A cycle with `in_valid`=0 changes no sum, whatever `in_act`, `in_wgt`, `in_start` or `in_last` carry.
- R7: If the final beat is sampled at clock edge n, `out_valid` is high only for the cycle after edge n+3 and is low after edges n+1 and n+2. `out_lanes` holds its value until the next result.
- R8: Every lane is exact for runs of up to DEPTH beats, including when all lower lanes are at their most negative sums. The lane-0 tracker always matches the accumulator's low bits, and each upper lane's correction is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat qualifier |
| in_start | input | 1 | First beat of a run (clears the sums) |
| in_last | input | 1 | Final beat of a run |
| in_signed | input | 1 | 1: activations are two's complement; 0: unsigned |
| in_act | input | NLANE*AW | Packed activations, lane i at bits i*AW |
| in_wgt | input | WW | Shared signed weight |
| out_valid | output | 1 | One-cycle result strobe |
| out_lanes | output | NLANE*LANE_W | Per-lane signed results, lane i at bits i*LANE_W |

## Verification
A wrong borrow correction or a corrupted lane tracker affects only the lanes above the faulty point. It shows up as an upper-lane result that is off by exactly one, at the `out_valid` pulse of the same run. Negative lower-lane sums are therefore driven deliberately, including all-minimum activations. A tracker that loses sync with the accumulator trips the internal consistency properties on the next clock. A fault in start or idle handling makes a whole run's results wrong, and this is visible four edges after that run's last beat.

// File: rtl/sdv_pkg.sv
package sdv_pkg;
  localparam int PRE_W   = 27;  // pre-adder / multiplier A width
  localparam int MULB_W  = 18;  // multiplier B width
  localparam int ACC_W   = 48;  // accumulator width
  localparam int PROD_W  = PRE_W + MULB_W;
  localparam int MAG_TOP = PRE_W - 1; // magnitude bits allowed below sign of pre-adder

  typedef logic [1:0] mod4_t;
endpackage

// File: rtl/sdv_pack.sv
module sdv_pack
  import sdv_pkg::*;
#(
  parameter int NLANE  = 3,
  parameter int AW     = 4,
  parameter int LANE_W = 11
) (
  input  logic [NLANE*AW-1:0] act,
  input  logic                is_signed,
  input  logic [1:0]          w_lo,
  output logic [PRE_W-1:0]    mag_word,
  output logic [PRE_W-1:0]    sign_word,
  output logic [2*NLANE-1:0]  part
);
  // split each activation: top bit goes to the sign word when signed
  always_comb begin
    mag_word  = '0;
    sign_word = '0;
    for (int i = 0; i < NLANE; i++) begin
      for (int b = 0; b < AW; b++) begin
        if (is_signed && (b == AW - 1))
          sign_word[i*LANE_W + b] = act[i*AW + b];
        else
          mag_word[i*LANE_W + b]  = act[i*AW + b];
      end
    end
  end

  // low two bits of each lane's partial product, for the tracker
  for (genvar g = 0; g < NLANE; g++) begin : g_part
    logic [AW-1:0] x;
    logic [AW:0]   xv;
    assign x  = act[g*AW +: AW];
    assign xv = is_signed ? {x[AW-1], x} : {1'b0, x};
    assign part[2*g +: 2] = xv[1:0] * w_lo;
  end
endmodule

// File: rtl/sdv_lane_mon.sv
module sdv_lane_mon
  import sdv_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  logic  clr,
  input  mod4_t part,
  output mod4_t mod4
);
  always_ff @(posedge clk) begin
    if (rst)
      mod4 <= '0;
    else if (en)
      mod4 <= clr ? part : mod4_t'(mod4 + part);
  end
endmodule

// File: rtl/sdv_extract.sv
module sdv_extract
  import sdv_pkg::*;
#(
  parameter int NLANE  = 3,
  parameter int LANE_W = 11
) (
  input  logic [ACC_W-1:0]        acc,
  input  logic [2*NLANE-1:0]      mon,
  output logic [NLANE*LANE_W-1:0] lanes
);
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [LANE_W-1:0] fld;
    assign fld = acc[g*LANE_W +: LANE_W];
    if (g == 0) begin : g_base
      assign lanes[g*LANE_W +: LANE_W] = fld;
    end else begin : g_upper
      logic borrow;
      assign borrow = (fld[1:0] != mon[2*g +: 2]);
      assign lanes[g*LANE_W +: LANE_W] = fld + LANE_W'(borrow);
    end
  end
endmodule

// File: rtl/sdv_mac_top.sv
module sdv_mac_top
  import sdv_pkg::*;
#(
  parameter int NLANE = 3,
  parameter int AW    = 4,
  parameter int WW    = 4,
  parameter int DEPTH = 8,
  localparam int LANE_W = AW + WW + $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    in_start,
  input  logic                    in_last,
  input  logic                    in_signed,
  input  logic [NLANE*AW-1:0]     in_act,
  input  logic [WW-1:0]           in_wgt,
  output logic                    out_valid,
  output logic [NLANE*LANE_W-1:0] out_lanes
);
  // sizing checks at elaboration
  if ((NLANE - 1) * LANE_W + AW > MAG_TOP) begin : g_bad_pack
    $error("packed operand exceeds pre-adder width");
  end
  if (NLANE * LANE_W > ACC_W) begin : g_bad_acc
    $error("lanes exceed accumulator width");
  end
  if (AW < 1 || AW > 8 || WW < 1 || WW > 8) begin : g_bad_width
    $error("operand width outside 1..8");
  end

  // stage 0: pack
  logic [PRE_W-1:0]   mag_d, sgn_d;
  logic [2*NLANE-1:0] part_d;

  sdv_pack #(.NLANE(NLANE), .AW(AW), .LANE_W(LANE_W)) u_pack (
    .act       (in_act),
    .is_signed (in_signed),
    .w_lo      (WW > 1 ? in_wgt[1:0] : {2{in_wgt[0]}}),
    .mag_word  (mag_d),
    .sign_word (sgn_d),
    .part      (part_d)
  );

  // stage 1 registers
  logic [PRE_W-1:0]   mag_q, sgn_q;
  logic [WW-1:0]      w_q;
  logic [2*NLANE-1:0] part1_q;
  logic               v1_q, st1_q, la1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mag_q <= '0; sgn_q <= '0; w_q <= '0; part1_q <= '0;
      v1_q <= 1'b0; st1_q <= 1'b0; la1_q <= 1'b0;
    end else begin
      v1_q    <= in_valid;
      st1_q   <= in_valid & in_start;
      la1_q   <= in_valid & in_last;
      mag_q   <= mag_d;
      sgn_q   <= sgn_d;
      w_q     <= in_wgt;
      part1_q <= part_d;
    end
  end

  // stage 2: pre-adder and multiplier
  logic signed [PRE_W-1:0]  pre;
  logic signed [MULB_W-1:0] w_ext;
  logic signed [PROD_W-1:0] prod_d, prod_q;
  logic [2*NLANE-1:0]       part2_q;
  logic                     v2_q, st2_q, la2_q;

  assign pre    = $signed(mag_q) - $signed(sgn_q);
  assign w_ext  = MULB_W'($signed(w_q));
  assign prod_d = pre * w_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q <= '0; part2_q <= '0;
      v2_q <= 1'b0; st2_q <= 1'b0; la2_q <= 1'b0;
    end else begin
      prod_q  <= prod_d;
      part2_q <= part1_q;
      v2_q    <= v1_q;
      st2_q   <= st1_q;
      la2_q   <= la1_q;
    end
  end

  // stage 3: accumulate and track lanes mod 4
  logic signed [ACC_W-1:0] acc_q;
  logic [2*NLANE-1:0]      mon_q;
  logic                    la3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      la3_q <= 1'b0;
    end else begin
      la3_q <= v2_q & la2_q;
      if (v2_q)
        acc_q <= st2_q ? ACC_W'(prod_q) : acc_q + ACC_W'(prod_q);
    end
  end

  for (genvar g = 0; g < NLANE; g++) begin : g_mon
    sdv_lane_mon u_mon (
      .clk  (clk),
      .rst  (rst),
      .en   (v2_q),
      .clr  (st2_q),
      .part (part2_q[2*g +: 2]),
      .mod4 (mon_q[2*g +: 2])
    );
  end

  // stage 4: extract and register results
  logic [NLANE*LANE_W-1:0] lanes_d;

  sdv_extract #(.NLANE(NLANE), .LANE_W(LANE_W)) u_ext (
    .acc   (acc_q),
    .mon   (mon_q),
    .lanes (lanes_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_lanes <= '0;
    end else begin
      out_valid <= la3_q;
      if (la3_q)
        out_lanes <= lanes_d;
    end
  end
endmodule

// File: rtl/sdv_mac_chk.sv
module sdv_mac_chk
  import sdv_pkg::*;
#(
  parameter int NLANE  = 3,
  parameter int LANE_W = 11
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_last,
  input logic               out_valid,
  input logic [ACC_W-1:0]   acc,
  input logic [2*NLANE-1:0] mon
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R7
  strobe_latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && in_last, 4));

  // R8
  lane0_track_chk: assert property (@(posedge clk) disable iff (rst)
    acc[1:0] == mon[1:0]);

  for (genvar g = 1; g < NLANE; g++) begin : g_upper
    logic [1:0] gap;
    assign gap = mon[2*g +: 2] - acc[g*LANE_W +: 2];
    // R8
    borrow_bound_chk: assert property (@(posedge clk) disable iff (rst)
      gap <= 2'd1);
  end
endmodule

bind sdv_mac_top sdv_mac_chk #(.NLANE(NLANE), .LANE_W(LANE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_last   (in_last),
  .out_valid (out_valid),
  .acc       (acc_q),
  .mon       (mon_q)
);

// File: tb/sim_sdv_mac_top.sv
module sim_sdv_mac_top;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 3;
  localparam int AW = 4;
  localparam int WW = 4;
  localparam int DP = 8;
  localparam int LW = AW + WW + $clog2(DP);

  logic clk = 1'b0;
  logic rst, in_valid, in_start, in_last, in_signed;
  logic [NL*AW-1:0] in_act;
  logic [WW-1:0]    in_wgt;
  logic             out_valid;
  logic [NL*LW-1:0] out_lanes;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdv_mac_top #(.NLANE(NL), .AW(AW), .WW(WW), .DEPTH(DP)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
    .in_last(in_last), .in_signed(in_signed), .in_act(in_act),
    .in_wgt(in_wgt), .out_valid(out_valid), .out_lanes(out_lanes)
  );

  logic [NL*AW-1:0] b_act [DP];
  logic [WW-1:0]    b_w   [DP];
  logic             b_sg  [DP];

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int aval(input logic [AW-1:0] x, input logic s);
    if (s) return int'($signed(x));
    return int'(x);
  endfunction

  function automatic int lane_out(input int i);
    logic [LW-1:0] f;
    f = out_lanes[i*LW +: LW];
    return int'($signed(f));
  endfunction

  task automatic idle();
    in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0;
  endtask

  // beats without a last flag (abandoned run)
  task automatic drive_open(input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      in_valid = 1'b1; in_start = (j == 0); in_last = 1'b0;
      in_signed = 1'b1; in_act = NL*AW'($urandom); in_wgt = WW'($urandom);
    end
    @(negedge clk);
    idle();
  endtask

  // run n beats from the b_* arrays; gap idle cycles with junk between beats
  task automatic run_beats(input string tag, input int n, input int gap);
    int ref_sum [NL];
    int prev [NL];
    for (int i = 0; i < NL; i++) ref_sum[i] = 0;
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      in_valid = 1'b1; in_start = (j == 0); in_last = (j == n - 1);
      in_signed = b_sg[j]; in_act = b_act[j]; in_wgt = b_w[j];
      for (int i = 0; i < NL; i++)
        ref_sum[i] += aval(b_act[j][i*AW +: AW], b_sg[j]) * int'($signed(b_w[j]));
      if (j != n - 1) begin
        for (int k = 0; k < gap; k++) begin
          @(negedge clk);
          // R6: junk with valid low, start and last set
          in_valid = 1'b0; in_start = 1'b1; in_last = 1'b1;
          in_act = NL*AW'($urandom); in_wgt = WW'($urandom);
        end
      end
    end
    @(negedge clk);
    idle();
    @(negedge clk);
    @(negedge clk);
    chk({tag, " R7 no early strobe"}, int'(out_valid), 0);
    @(negedge clk);
    chk({tag, " R7 strobe"}, int'(out_valid), 1);
    for (int i = 0; i < NL; i++) begin
      prev[i] = lane_out(i);
      chk($sformatf("%s lane%0d", tag, i), lane_out(i), ref_sum[i]);
    end
    @(negedge clk);
    chk({tag, " R7 single cycle"}, int'(out_valid), 0);
    for (int i = 0; i < NL; i++)
      chk($sformatf("%s R7 hold lane%0d", tag, i), lane_out(i), prev[i]);
  endtask

  task automatic fill_random(input int n, input int mode);
    for (int j = 0; j < n; j++) begin
      b_act[j] = NL*AW'($urandom);
      b_w[j]   = WW'($urandom);
      b_sg[j]  = (mode == 2) ? 1'($urandom) : 1'(mode);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; idle(); in_signed = 1'b0; in_act = '0; in_wgt = '0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after reset", int'(out_valid), 0);
    chk("R1 lanes after reset", int'(out_lanes != '0), 0);
  endtask

  task automatic t_signed();
    b_act[0] = {4'd3, 4'hE, 4'd5}; b_w[0] = 4'd3; b_sg[0] = 1'b1;
    run_beats("R2 single", 1, 0);
    for (int r = 0; r < 4; r++) begin
      fill_random(DP, 1);
      run_beats("R2 random", 1 + (r * 7) % DP, 0);
    end
  endtask

  task automatic t_unsigned();
    for (int j = 0; j < DP; j++) begin
      b_act[j] = {NL{4'hF}}; b_w[j] = 4'h8; b_sg[j] = 1'b0;
    end
    run_beats("R3 max unsigned", DP, 0);
    fill_random(DP, 0);
    run_beats("R3 random", DP, 0);
  endtask

  task automatic t_mixed();
    fill_random(DP, 2);
    run_beats("R4 mixed", DP, 0);
  endtask

  task automatic t_start();
    drive_open(5);
    fill_random(3, 1);
    run_beats("R5 restart", 3, 0);
  endtask

  task automatic t_idle();
    fill_random(5, 2);
    run_beats("R6 gaps", 5, 2);
  endtask

  task automatic t_borrow();
    for (int j = 0; j < DP; j++) begin
      b_act[j] = {NL{4'h8}}; b_w[j] = 4'd7; b_sg[j] = 1'b1;
    end
    run_beats("R8 all min pos w", DP, 0);
    for (int j = 0; j < DP; j++) b_w[j] = 4'h8;
    run_beats("R8 all min neg w", DP, 0);
    for (int j = 0; j < DP; j++) begin
      b_act[j] = {4'd7, 4'h8, 4'h8}; b_w[j] = 4'd7;
    end
    run_beats("R8 chain", DP, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_signed();
    t_unsigned();
    t_mixed();
    t_start();
    t_idle();
    t_borrow();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule